// File: doc/BRIEF.md
# Character Display Host Register Port

This block sits between a system controller's 8-bit parallel bus and the internal logic of a character display controller. The host presents a register-select line, a read/write line and an enable strobe. The block acts on each access when it sees the enable strobe fall. With register select low, a write loads a write-only instruction register and hands the code to the instruction execution engine. A read with register select low returns a status byte. That byte carries the busy flag in the top bit and the engine's address counter in the lower seven bits. With register select high, accesses go through an 8-bit data register. A write passes its byte on toward display or character RAM. A read returns whatever the data register holds.

While an accepted instruction is executing, busy stays high and any further instruction write is dropped. Data reads are served from a byte fetched in advance. When the engine reports that the address counter has moved, the block requests a RAM read and latches the returned byte into the data register. A later host data read therefore finishes without waiting for the RAM. A synchronous reset returns the block to its idle state, and so does a held power-down input.

Top module: `lcd_host_regif`

## Requirements
- R1: After synchronous reset, busy is 0, the instruction register (seen on `instrCode`) is 0x00 and the data register is 0x00.
- R2: While the host reads with register select 0 (enable high, read/write 1), `hostDout[7]` equals the busy flag and `hostDout[6:0]` equals `acValue`.
- R3: The host can never read the instruction register back. A register-select-0 read returns only the status byte, whatever code was last written.
- R4: An instruction write (register select 0, read/write 0) taken while busy is 0 loads `hostDin` into `instrCode`, raises `instrValid` for exactly one cycle and sets busy. Both results are visible in the cycle after the strobe is detected.
- R5: An instruction write taken while busy is 1 is dropped: `instrCode` keeps its value and `instrValid` stays low.
- R6: A one-cycle `execDone` clears busy on the following clock edge.
- R7: After an `acChanged` pulse, `ramRdReq` goes high and stays high until `ramRdAck`. The acknowledge cycle loads `ramRdData` into the data register and drops the request.
- R8: A data read (register select 1, read/write 1) returns the data register on `hostDout` and produces a one-cycle `dataRdDone` pulse after the strobe.
- R9: A data write (register select 1, read/write 0) loads `hostDin` into the data register and produces a one-cycle `dataWrReq` pulse, with that byte on `dataWrByte`.
- R10: `hostOe` is high only while enable is high and read/write is 1. While it is low, `hostDout` is 0x00.
- R11: An access takes effect once, on the falling edge of enable. Holding enable high across many clocks causes no action until it falls.
- R12: While `powerDown` is high, the block is held in the R1 state and host accesses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstSync | input | 1 | Synchronous reset, active high |
| powerDown | input | 1 | Holds the reset state while high |
| hostEn | input | 1 | Host enable strobe; the access is taken on its falling edge |
| hostRs | input | 1 | Register select: 0 instruction/status, 1 data |
| hostRw | input | 1 | 1 read, 0 write |
| hostDin | input | 8 | Host write data |
| hostDout | output | 8 | Host read data |
| hostOe | output | 1 | Output enable for the host bus driver |
| acValue | input | 7 | Current address counter from the engine |
| instrCode | output | 8 | Instruction register contents |
| instrValid | output | 1 | One-cycle pulse for a new accepted instruction |
| execDone | input | 1 | Engine pulse: instruction finished |
| dataWrReq | output | 1 | One-cycle pulse: RAM write of `dataWrByte` |
| dataWrByte | output | 8 | Byte to write to RAM |
| dataRdDone | output | 1 | One-cycle pulse: host consumed the data register |
| acChanged | input | 1 | Engine pulse: address counter moved, fetch again |
| ramRdReq | output | 1 | RAM read request, held until acknowledged |
| ramRdAck | input | 1 | RAM read acknowledge, with data valid |
| ramRdData | input | 8 | RAM read data |

## Verification
The hardest case to reach is an instruction write that arrives while busy is still set, especially when the write and `execDone` fall in the same window. In that case the write must be dropped even though busy falls straight afterwards. The random sequence mixes instruction writes, completion pulses, data accesses and fetches with no ordering rule, so writes often land on a busy block. A directed pass then forces the busy-write case and the powerDown case with a pending state. A bench model tracks busy, the instruction register and the data register, and predicts every bus byte from that model.

// File: rtl/lcd_regif_pkg.sv
package lcd_regif_pkg;

  typedef enum logic [2:0] {
    ACC_NONE      = 3'd0,
    ACC_INSTR_WR  = 3'd1,
    ACC_STATUS_RD = 3'd2,
    ACC_DATA_WR   = 3'd3,
    ACC_DATA_RD   = 3'd4
  } accessKindT;

  typedef struct packed {
    logic loadIr;
    logic loadDrHost;
    logic loadDrRam;
    logic pulseInstr;
    logic pulseWr;
    logic pulseRd;
    logic clearAll;
  } regStrobeT;

endpackage

// File: rtl/lcd_regif_ctrl.sv
module lcd_regif_ctrl
  import lcd_regif_pkg::*;
(
  input  logic       clk,
  input  logic       rstSync,
  input  logic       powerDown,
  input  logic       hostEn,
  input  logic       hostRs,
  input  logic       hostRw,
  input  logic       execDone,
  input  logic       acChanged,
  input  logic       ramRdAck,
  output logic       busyFlag,
  output logic       ramRdReq,
  output regStrobeT  strobes
);

  logic       clearAll;
  logic       enPrev;
  logic       fallSeen;
  logic       rdPending;
  logic       ramLand;
  accessKindT accKind;
  logic       takeInstr;

  assign clearAll = rstSync | powerDown;

  // Enable history for detecting its falling edge
  always_ff @(posedge clk) begin
    if (clearAll) enPrev <= 1'b0;
    else          enPrev <= hostEn;
  end

  assign fallSeen = enPrev & ~hostEn;

  // Work out what kind of access the strobe carries
  always_comb begin
    accKind = ACC_NONE;
    if (fallSeen) begin
      unique case ({hostRs, hostRw})
        2'b00:   accKind = ACC_INSTR_WR;
        2'b01:   accKind = ACC_STATUS_RD;
        2'b10:   accKind = ACC_DATA_WR;
        default: accKind = ACC_DATA_RD;
      endcase
    end
  end

  assign takeInstr = (accKind == ACC_INSTR_WR) && !busyFlag;

  // Busy: set by an accepted instruction, cleared by the engine
  always_ff @(posedge clk) begin
    if (clearAll)       busyFlag <= 1'b0;
    else if (takeInstr) busyFlag <= 1'b1;
    else if (execDone)  busyFlag <= 1'b0;
  end

  // RAM fetch into the data register
  assign ramLand = rdPending & ramRdAck;

  always_ff @(posedge clk) begin
    if (clearAll)       rdPending <= 1'b0;
    else if (acChanged) rdPending <= 1'b1;
    else if (ramLand)   rdPending <= 1'b0;
  end

  assign ramRdReq = rdPending;

  always_comb begin
    strobes            = '0;
    strobes.clearAll   = clearAll;
    strobes.loadIr     = takeInstr;
    strobes.pulseInstr = takeInstr;
    strobes.loadDrHost = (accKind == ACC_DATA_WR);
    strobes.pulseWr    = (accKind == ACC_DATA_WR);
    strobes.pulseRd    = (accKind == ACC_DATA_RD);
    // a host data write in the same cycle wins over landing RAM data
    strobes.loadDrRam  = ramLand && (accKind != ACC_DATA_WR);
  end

endmodule

// File: rtl/lcd_regif_datapath.sv
module lcd_regif_datapath
  import lcd_regif_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int AC_W   = 7
) (
  input  logic              clk,
  input  regStrobeT         strobes,
  input  logic              hostEn,
  input  logic              hostRs,
  input  logic              hostRw,
  input  logic [DATA_W-1:0] hostDin,
  input  logic [AC_W-1:0]   acValue,
  input  logic              busyFlag,
  input  logic [DATA_W-1:0] ramRdData,
  output logic [DATA_W-1:0] hostDout,
  output logic              hostOe,
  output logic [DATA_W-1:0] instrCode,
  output logic              instrValid,
  output logic              dataWrReq,
  output logic [DATA_W-1:0] dataWrByte,
  output logic              dataRdDone
);

  localparam int STATUS_W = AC_W + 1;

  logic [DATA_W-1:0]   instrReg;
  logic [DATA_W-1:0]   dataReg;
  logic [STATUS_W-1:0] statusWord;

  // Parameter consistency check
  generate
    if (STATUS_W != DATA_W) begin : g_badWidth
      initial $error("status word width must equal bus width");
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobes.clearAll)    instrReg <= '0;
    else if (strobes.loadIr) instrReg <= hostDin;
  end

  always_ff @(posedge clk) begin
    if (strobes.clearAll)         dataReg <= '0;
    else if (strobes.loadDrHost)  dataReg <= hostDin;
    else if (strobes.loadDrRam)   dataReg <= ramRdData;
  end

  always_ff @(posedge clk) begin
    if (strobes.clearAll) begin
      instrValid <= 1'b0;
      dataWrReq  <= 1'b0;
      dataRdDone <= 1'b0;
    end else begin
      instrValid <= strobes.pulseInstr;
      dataWrReq  <= strobes.pulseWr;
      dataRdDone <= strobes.pulseRd;
    end
  end

  assign statusWord = {busyFlag, acValue};
  assign hostOe     = hostEn & hostRw;
  assign hostDout   = !hostOe ? '0 : (hostRs ? dataReg : statusWord);
  assign instrCode  = instrReg;
  assign dataWrByte = dataReg;

endmodule

// File: rtl/lcd_host_regif.sv
module lcd_host_regif
  import lcd_regif_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int AC_W   = 7
) (
  input  logic              clk,
  input  logic              rstSync,
  input  logic              powerDown,
  input  logic              hostEn,
  input  logic              hostRs,
  input  logic              hostRw,
  input  logic [DATA_W-1:0] hostDin,
  output logic [DATA_W-1:0] hostDout,
  output logic              hostOe,
  input  logic [AC_W-1:0]   acValue,
  output logic [DATA_W-1:0] instrCode,
  output logic              instrValid,
  input  logic              execDone,
  output logic              dataWrReq,
  output logic [DATA_W-1:0] dataWrByte,
  output logic              dataRdDone,
  input  logic              acChanged,
  output logic              ramRdReq,
  input  logic              ramRdAck,
  input  logic [DATA_W-1:0] ramRdData
);

  regStrobeT strobes;
  logic      busyFlag;

  lcd_regif_ctrl ctrl_i (
    .clk       (clk),
    .rstSync   (rstSync),
    .powerDown (powerDown),
    .hostEn    (hostEn),
    .hostRs    (hostRs),
    .hostRw    (hostRw),
    .execDone  (execDone),
    .acChanged (acChanged),
    .ramRdAck  (ramRdAck),
    .busyFlag  (busyFlag),
    .ramRdReq  (ramRdReq),
    .strobes   (strobes)
  );

  lcd_regif_datapath #(.DATA_W(DATA_W), .AC_W(AC_W)) dp_i (
    .clk        (clk),
    .strobes    (strobes),
    .hostEn     (hostEn),
    .hostRs     (hostRs),
    .hostRw     (hostRw),
    .hostDin    (hostDin),
    .acValue    (acValue),
    .busyFlag   (busyFlag),
    .ramRdData  (ramRdData),
    .hostDout   (hostDout),
    .hostOe     (hostOe),
    .instrCode  (instrCode),
    .instrValid (instrValid),
    .dataWrReq  (dataWrReq),
    .dataWrByte (dataWrByte),
    .dataRdDone (dataRdDone)
  );

endmodule

// File: rtl/lcd_host_regif_chk.sv
module lcd_host_regif_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstSync,
  input logic              powerDown,
  input logic              hostRs,
  input logic              hostOe,
  input logic [DATA_W-1:0] hostDout,
  input logic              busyFlag,
  input logic [DATA_W-1:0] instrCode,
  input logic              instrValid,
  input logic              execDone,
  input logic              dataRdDone,
  input logic              acChanged,
  input logic              ramRdReq,
  input logic              ramRdAck
);

  // R2
  status_busy_bit_chk: assert property (@(posedge clk) disable iff (rstSync || powerDown)
    (hostOe && !hostRs) |-> (hostDout[DATA_W-1] == busyFlag));

  // R4
  instr_sets_busy_chk: assert property (@(posedge clk) disable iff (rstSync || powerDown)
    instrValid |-> busyFlag);

  // R4
  instr_pulse_single_chk: assert property (@(posedge clk) disable iff (rstSync || powerDown)
    instrValid |=> !instrValid);

  // R5
  busy_holds_code_chk: assert property (@(posedge clk) disable iff (rstSync || powerDown)
    busyFlag |=> $stable(instrCode));

  // R6
  done_clears_busy_chk: assert property (@(posedge clk) disable iff (rstSync || powerDown)
    (execDone && busyFlag) |=> !busyFlag);

  // R7
  fetch_req_held_chk: assert property (@(posedge clk) disable iff (rstSync || powerDown)
    (ramRdReq && !ramRdAck && !acChanged) |=> ramRdReq);

  // R8
  rd_pulse_single_chk: assert property (@(posedge clk) disable iff (rstSync || powerDown)
    dataRdDone |=> !dataRdDone);

  // R12
  pd_forces_idle_chk: assert property (@(posedge clk) disable iff (rstSync)
    powerDown |=> (!busyFlag && instrCode == '0 && !ramRdReq));

endmodule

bind lcd_host_regif lcd_host_regif_chk #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rstSync    (rstSync),
  .powerDown  (powerDown),
  .hostRs     (hostRs),
  .hostOe     (hostOe),
  .hostDout   (hostDout),
  .busyFlag   (busyFlag),
  .instrCode  (instrCode),
  .instrValid (instrValid),
  .execDone   (execDone),
  .dataRdDone (dataRdDone),
  .acChanged  (acChanged),
  .ramRdReq   (ramRdReq),
  .ramRdAck   (ramRdAck)
);

// File: tb/lcd_host_regif_tb_top.sv
module lcd_host_regif_tb_top;

  logic       clk = 1'b0;
  logic       rstSync = 1'b1;
  logic       powerDown = 1'b0;
  logic       hostEn = 1'b0;
  logic       hostRs = 1'b0;
  logic       hostRw = 1'b0;
  logic [7:0] hostDin = '0;
  logic [7:0] hostDout;
  logic       hostOe;
  logic [6:0] acValue = '0;
  logic [7:0] instrCode;
  logic       instrValid;
  logic       execDone = 1'b0;
  logic       dataWrReq;
  logic [7:0] dataWrByte;
  logic       dataRdDone;
  logic       acChanged = 1'b0;
  logic       ramRdReq;
  logic       ramRdAck = 1'b0;
  logic [7:0] ramRdData = '0;

  int testsRun = 0;
  int testsFailed = 0;
  logic       busyM = 1'b0;
  logic [7:0] irM = '0;
  logic [7:0] drM = '0;

  always #5 clk = ~clk;

  lcd_host_regif dut_i (
    .clk(clk), .rstSync(rstSync), .powerDown(powerDown),
    .hostEn(hostEn), .hostRs(hostRs), .hostRw(hostRw), .hostDin(hostDin),
    .hostDout(hostDout), .hostOe(hostOe), .acValue(acValue),
    .instrCode(instrCode), .instrValid(instrValid), .execDone(execDone),
    .dataWrReq(dataWrReq), .dataWrByte(dataWrByte), .dataRdDone(dataRdDone),
    .acChanged(acChanged), .ramRdReq(ramRdReq), .ramRdAck(ramRdAck),
    .ramRdData(ramRdData)
  );

  function automatic logic [7:0] statusOf(logic b, logic [6:0] ac);
    return {b, ac};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // write access; returns at the negedge where registered results show
  task automatic hostWrite(logic rs, logic [7:0] d);
    @(negedge clk); hostRs = rs; hostRw = 1'b0; hostDin = d; hostEn = 1'b1;
    @(negedge clk); hostEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic hostRead(logic rs, output logic [7:0] d, output logic oe);
    @(negedge clk); hostRs = rs; hostRw = 1'b1; hostEn = 1'b1;
    #1; d = hostDout; oe = hostOe;
    @(negedge clk); hostEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic engineDone();
    @(negedge clk); execDone = 1'b1;
    @(negedge clk); execDone = 1'b0;
    busyM = 1'b0;
  endtask

  task automatic fetchByte(logic [7:0] d, string tag);
    @(negedge clk); acChanged = 1'b1;
    @(negedge clk); acChanged = 1'b0;
    check({tag, " R7 req raised"}, ramRdReq, 1);
    @(negedge clk);
    check({tag, " R7 req held"}, ramRdReq, 1);
    ramRdAck = 1'b1; ramRdData = d;
    @(negedge clk); ramRdAck = 1'b0;
    check({tag, " R7 req dropped"}, ramRdReq, 0);
    drM = d;
  endtask

  task automatic instrOp(logic [7:0] d, string tag);
    hostWrite(1'b0, d);
    check({tag, " R4/R5 instrCode"}, instrCode, busyM ? irM : d);
    check({tag, " R4/R5 instrValid"}, instrValid, !busyM);
    if (!busyM) begin irM = d; busyM = 1'b1; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic       oe;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rstSync = 1'b0;

    // R1 reset state
    @(negedge clk);
    check("R1 instrCode", instrCode, 8'h00);
    acValue = 7'h00;
    hostRead(1'b0, rd, oe);
    check("R1 status", rd, 8'h00);
    hostRead(1'b1, rd, oe);
    check("R1 data reg", rd, 8'h00);
    check("R8 rd pulse", dataRdDone, 1);
    @(negedge clk);
    check("R8 rd pulse gone", dataRdDone, 0);

    // R10 output enable
    hostEn = 1'b1; hostRw = 1'b0; hostRs = 1'b1; #1;
    check("R10 oe write", hostOe, 0);
    check("R10 dout idle", hostDout, 8'h00);
    hostRw = 1'b1; #1;
    check("R10 oe read", hostOe, 1);
    hostEn = 1'b0; #1;
    check("R10 oe en low", hostOe, 0);
    @(negedge clk); @(negedge clk);

    // R4 accepted write, R3 status never shows IR
    instrOp(8'hA5, "dir");
    @(negedge clk);
    check("R4 pulse one cycle", instrValid, 0);
    acValue = 7'h12;
    hostRead(1'b0, rd, oe);
    check("R3 status not IR", rd, statusOf(1'b1, 7'h12));
    // R5 write while busy dropped
    instrOp(8'h3C, "busy");
    // R6 done clears busy
    engineDone();
    hostRead(1'b0, rd, oe);
    check("R6 busy cleared", rd, statusOf(1'b0, 7'h12));

    // R11 held enable takes no action
    @(negedge clk); hostRs = 1'b0; hostRw = 1'b0; hostDin = 8'h5A; hostEn = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check("R11 no early action", {instrValid, instrCode}, {1'b0, 8'hA5});
    end
    hostEn = 1'b0;
    @(negedge clk);
    check("R11 action on fall", {instrValid, instrCode}, {1'b1, 8'h5A});
    irM = 8'h5A; busyM = 1'b1;
    engineDone();

    // R9 data write, R7 fetch, R8 data read
    hostWrite(1'b1, 8'hC3);
    check("R9 wr pulse", {dataWrReq, dataWrByte}, {1'b1, 8'hC3});
    drM = 8'hC3;
    fetchByte(8'h7E, "dir");
    hostRead(1'b1, rd, oe);
    check("R8 data read", rd, 8'h7E);

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      case ($urandom_range(0, 5))
        0: instrOp(b, "rnd");
        1: engineDone();
        2: begin
          hostWrite(1'b1, b);
          check("R9 rnd wr", {dataWrReq, dataWrByte}, {1'b1, b});
          drM = b;
        end
        3: begin
          acValue = 7'(b);
          hostRead(1'b0, rd, oe);
          check("R2 rnd status", {oe, rd}, {1'b1, statusOf(busyM, 7'(b))});
        end
        4: begin
          hostRead(1'b1, rd, oe);
          check("R8 rnd data", {rd, dataRdDone}, {drM, 1'b1});
        end
        default: fetchByte(b, "rnd");
      endcase
    end

    // R12 power-down with busy and data held
    if (!busyM) instrOp(8'h11, "pd");
    hostWrite(1'b1, 8'h99);
    @(negedge clk); powerDown = 1'b1;
    hostWrite(1'b0, 8'h44);
    check("R12 no instr in pd", {instrValid, instrCode}, {1'b0, 8'h00});
    @(negedge clk); powerDown = 1'b0;
    busyM = 1'b0; irM = '0; drM = '0;
    acValue = 7'h05;
    hostRead(1'b0, rd, oe);
    check("R12 busy cleared", rd, statusOf(1'b0, 7'h05));
    hostRead(1'b1, rd, oe);
    check("R12 data cleared", rd, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule